// File: doc/BRIEF.md
# Wormhole Output Port with Round-Robin Input Selection

This block is the output side of one port of a five-input on-chip network router. Each input buffer tells the port, per service level, whether its head flit wants this output, and shows that flit. The port keeps one lane per service level. Each lane holds its own round-robin pointer and its own packet lock. A lane may send only when the downstream buffer reports space for that level. Each cycle the port picks one lane with an eligible flit. It pulses a read strobe back to the chosen input buffer and registers the flit onto the output link.

Wormhole packets are the reason for the lock. Once a lane has forwarded a flit that does not end a packet, it serves only that input until an end-of-packet or single-flit packet has gone out. The pointer then moves past the input that just finished. Lanes, inputs and packets follow each other with no dead cycle in between. When nothing can be sent, the link carries an all-zero idle flit.

Top module: `noc_out_port`

## Requirements
- R1: While a lane is unlocked, it serves the first requesting input found by searching upward from its pointer and wrapping from input 4 to input 0.
- R2: The flit type is bits [15:14]: 00 idle, 01 body, 10 end of packet, 11 single-flit packet. After a lane forwards a type 10 or 11 flit from input i, it unlocks and its pointer becomes (i+1) mod 5. In every other cycle the pointer keeps its value.
- R3: After a lane forwards a type 01 flit from input i, it reads no other input until it has forwarded a type 10 or 11 flit from i. While input i has nothing waiting, the lane sends nothing.
- R4: A lane whose downstream space bit is low issues no read.
- R5: Each lane keeps its own lock and pointer. A packet that is open on one lane does not affect selection on the other lane.
- R6: When both lanes are eligible in the same cycle, lane 0 (signaling) is served and lane 1 (read/write) waits.
- R7: At most one read strobe is high in any cycle, and only toward an input whose request bit for that lane is high.
- R8: A flit read in cycle t appears on out_flit in cycle t+1, with out_vld high and out_lvl holding the lane index.
- R9: In a cycle with no read, the next cycle shows out_vld low, out_flit all zeros and out_lvl zero.
- R10: While every input requests and every lane has space, out_vld stays high every cycle, across packet ends, input changes and lane changes.
- R11: A synchronous active-high reset unlocks both lanes, sets both pointers to 0 and makes the output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NSL*NIN (10) | Request bits, bit s*NIN+i: input i holds a flit for this output on lane s |
| in_flit | input | NSL*NIN*FW (160) | Head flits, same order as in_valid, FW bits each |
| nbs_ready | input | NSL (2) | Downstream buffer has space, one bit per lane |
| rd_en | output | NSL*NIN (10) | Read strobe to the input buffers, same order as in_valid |
| out_vld | output | 1 | A flit is on the output link |
| out_lvl | output | 1 | Lane of the flit on the link |
| out_flit | output | FW (16) | Output flit, all zeros when idle |

## Verification
Every cycle, the read strobes are compared against a lane-by-lane model. A wrong lock bit, owner or pointer therefore shows on rd_en in the very cycle the lane is next eligible. A packet would be broken up, or an input skipped or served twice. One cycle later the same fault shows on out_flit as a flit whose input, packet and index fields do not match the model. A lost grant or an added bubble shows as a missing out_vld during the saturated phase.

// File: rtl/noc_out_pkg.sv
package noc_out_pkg;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_BODY = 2'b01,
    FT_EOP  = 2'b10,
    FT_FULL = 2'b11
  } flit_kind_e;

  // A packet closes on either of the two types whose upper bit is set.
  function automatic logic closes_packet(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/noc_rr_pick.sv
module noc_rr_pick #(
  parameter int N  = 5,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!hit && req[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end

endmodule

// File: rtl/noc_sl_lane.sv
module noc_sl_lane
  import noc_out_pkg::*;
#(
  parameter int NIN = 5,
  parameter int FW  = 16,
  parameter int IW  = (NIN > 1) ? $clog2(NIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIN-1:0]  req,
  input  logic [NIN*FW-1:0] flits,
  input  logic            space,
  input  logic            take,
  output logic            eligible,
  output logic [IW-1:0]   cand,
  output logic [FW-1:0]   cand_flit
);

  logic          locked;
  logic [IW-1:0] owner;
  logic [IW-1:0] ptr;
  logic          rr_hit;
  logic [IW-1:0] rr_idx;
  logic          last;

  noc_rr_pick #(.N(NIN), .IW(IW)) i_pick (
    .req   (req),
    .start (ptr),
    .hit   (rr_hit),
    .idx   (rr_idx)
  );

  always_comb begin
    cand      = locked ? owner : rr_idx;
    eligible  = space && (locked ? req[owner] : rr_hit);
    cand_flit = flits[cand*FW +: FW];
    last      = closes_packet(cand_flit[FW-1 -: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (take) begin
      if (last) begin
        locked <= 1'b0;
        ptr    <= (int'(cand) == NIN - 1) ? '0 : cand + 1'b1;
      end else begin
        locked <= 1'b1;
        owner  <= cand;
      end
    end
  end

  a_r4_space: assert property (@(posedge clk) disable iff (rst)
    take |-> space);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (take && !last) |=> (locked && owner == $past(cand)));

  a_r2_ptr_still: assert property (@(posedge clk) disable iff (rst)
    !(take && last) |=> $stable(ptr));

  a_r1_pick_req: assert property (@(posedge clk) disable iff (rst)
    take |-> req[cand]);

endmodule

// File: rtl/noc_out_port.sv
module noc_out_port
  import noc_out_pkg::*;
#(
  parameter int NIN = 5,
  parameter int NSL = 2,
  parameter int FW  = 16,
  localparam int IW = (NIN > 1) ? $clog2(NIN) : 1,
  localparam int LW = (NSL > 1) ? $clog2(NSL) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSL*NIN-1:0]      in_valid,
  input  logic [NSL*NIN*FW-1:0]   in_flit,
  input  logic [NSL-1:0]          nbs_ready,
  output logic [NSL*NIN-1:0]      rd_en,
  output logic                    out_vld,
  output logic [LW-1:0]           out_lvl,
  output logic [FW-1:0]           out_flit
);

  logic [NSL-1:0] elig;
  logic [NSL-1:0] take;
  logic [IW-1:0]  cand  [NSL];
  logic [FW-1:0]  cflit [NSL];
  logic           sel_hit;
  logic [LW-1:0]  sel;

  for (genvar s = 0; s < NSL; s++) begin : g_lane
    noc_sl_lane #(.NIN(NIN), .FW(FW), .IW(IW)) i_lane (
      .clk       (clk),
      .rst       (rst),
      .req       (in_valid[s*NIN +: NIN]),
      .flits     (in_flit[s*NIN*FW +: NIN*FW]),
      .space     (nbs_ready[s]),
      .take      (take[s]),
      .eligible  (elig[s]),
      .cand      (cand[s]),
      .cand_flit (cflit[s])
    );
  end

  // Fixed priority between lanes: lowest index wins.
  always_comb begin
    sel_hit = 1'b0;
    sel     = '0;
    for (int s = 0; s < NSL; s++) begin
      if (!sel_hit && elig[s]) begin
        sel_hit = 1'b1;
        sel     = LW'(s);
      end
    end
    for (int s = 0; s < NSL; s++) begin
      take[s] = sel_hit && (int'(sel) == s);
    end
    for (int s = 0; s < NSL; s++) begin
      for (int i = 0; i < NIN; i++) begin
        rd_en[s*NIN + i] = take[s] && (int'(cand[s]) == i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_lvl  <= '0;
      out_flit <= '0;
    end else if (sel_hit) begin
      out_vld  <= 1'b1;
      out_lvl  <= sel;
      out_flit <= cflit[sel];
    end else begin
      out_vld  <= 1'b0;
      out_lvl  <= '0;
      out_flit <= '0;
    end
  end

  a_r7_one_read: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_en & ~in_valid) == '0);

  a_r8_out_after_read: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(|rd_en));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_flit == '0 && out_lvl == '0));

  for (genvar s = 1; s < NSL; s++) begin : g_prio
    a_r6_low_first: assert property (@(posedge clk) disable iff (rst)
      elig[0] |-> !(|rd_en[s*NIN +: NIN]));
  end

endmodule

// File: tb/test_noc_out_port.sv
module test_noc_out_port;

  localparam int NIN = 5;
  localparam int NSL = 2;
  localparam int FW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst;
  logic [NSL*NIN-1:0]    in_valid;
  logic [NSL*NIN*FW-1:0] in_flit;
  logic [NSL-1:0]        nbs_ready;
  logic [NSL*NIN-1:0]    rd_en;
  logic                  out_vld;
  logic [0:0]            out_lvl;
  logic [FW-1:0]         out_flit;

  noc_out_port #(.NIN(NIN), .NSL(NSL), .FW(FW)) i_noc_out_port (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .nbs_ready(nbs_ready), .rd_en(rd_en), .out_vld(out_vld),
    .out_lvl(out_lvl), .out_flit(out_flit)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_lock [NSL];
  int m_own  [NSL];
  int m_ptr  [NSL];
  int pk [NSL][NIN];
  int fi [NSL][NIN];
  logic [31:0]      lf = 32'h1badf00d;
  logic             e_vld = 1'b0;
  logic [0:0]       e_lvl = 1'b0;
  logic [FW-1:0]    e_flit = '0;
  logic [NSL*NIN-1:0] e_rd;

  function automatic int plen(int s, int i, int p);
    return ((s * 3 + i + p) % 4) + 1;
  endfunction

  function automatic logic [FW-1:0] mkf(int s, int i);
    int L;
    logic [1:0] t;
    L = plen(s, i, pk[s][i]);
    if (L == 1) t = 2'b11;
    else if (fi[s][i] == L - 1) t = 2'b10;
    else t = 2'b01;
    return {t, (s == 0) ? 2'b11 : 2'b10, 3'(i), 5'(pk[s][i]), 4'(fi[s][i])};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input int mode, input bit want_full);
    int sel;
    int cand [NSL];
    bit elig [NSL];
    @(negedge clk);
    chk(out_vld == e_vld && out_lvl == e_lvl && out_flit == e_flit,
        e_vld ? "R8" : "R9", {15'd0, out_vld, out_flit}, {15'd0, e_vld, e_flit});
    if (want_full) chk(out_vld == 1'b1, "R10", 32'(out_vld), 32'd1);
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    for (int s = 0; s < NSL; s++) begin
      for (int i = 0; i < NIN; i++) begin
        bit v;
        case (mode)
          1: v = lf[s*5 + i];
          3: v = (s == 0) ? (lf[i] & lf[i+5]) : lf[10+i];
          4: v = (s == 1);
          default: v = 1'b1;
        endcase
        in_valid[s*NIN + i] = v;
        in_flit[(s*NIN + i)*FW +: FW] = v ? mkf(s, i) : '0;
      end
      nbs_ready[s] = (mode == 2 || mode == 3) ? lf[20+s] : 1'b1;
    end
    #1;
    // reference selection
    sel = -1;
    for (int s = 0; s < NSL; s++) begin
      cand[s] = -1;
      if (m_lock[s] != 0) begin
        if (in_valid[s*NIN + m_own[s]]) cand[s] = m_own[s];
      end else begin
        for (int k = 0; k < NIN; k++) begin
          int j;
          j = (m_ptr[s] + k) % NIN;
          if (cand[s] < 0 && in_valid[s*NIN + j]) cand[s] = j;
        end
      end
      elig[s] = nbs_ready[s] && (cand[s] >= 0);
      if (sel < 0 && elig[s]) sel = s;
    end
    e_rd = '0;
    if (sel >= 0) e_rd[sel*NIN + cand[sel]] = 1'b1;
    chk(rd_en == e_rd, "R1/R2/R3/R4/R5/R6/R7", 32'(rd_en), 32'(e_rd));
    if (sel >= 0) begin
      int c;
      c = cand[sel];
      e_vld  = 1'b1;
      e_lvl  = 1'(sel);
      e_flit = mkf(sel, c);
      if (e_flit[15]) begin
        m_lock[sel] = 0;
        m_ptr[sel]  = (c + 1) % NIN;
      end else begin
        m_lock[sel] = 1;
        m_own[sel]  = c;
      end
      fi[sel][c]++;
      if (fi[sel][c] == plen(sel, c, pk[sel][c])) begin
        fi[sel][c] = 0;
        pk[sel][c]++;
      end
    end else begin
      e_vld  = 1'b0;
      e_lvl  = 1'b0;
      e_flit = '0;
    end
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSL; s++) begin
      m_lock[s] = 0; m_own[s] = 0; m_ptr[s] = 0;
      for (int i = 0; i < NIN; i++) begin pk[s][i] = 0; fi[s][i] = 0; end
    end
    rst = 1'b1;
    in_valid = '0;
    in_flit = '0;
    nbs_ready = '0;
    repeat (3) @(negedge clk);
    // R11: outputs idle while reset is held
    chk(out_vld == 1'b0 && out_flit == '0, "R11", {15'd0, out_vld, out_flit}, 32'd0);
    in_valid = '1;
    nbs_ready = '1;
    @(negedge clk);
    chk(out_vld == 1'b0 && out_flit == '0, "R11", {15'd0, out_vld, out_flit}, 32'd0);
    rst = 1'b0;
    in_valid = '0;
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 400; k++) cycle(m, (m == 0) && (k > 0));
    end
    @(negedge clk);
    chk(out_vld == e_vld && out_flit == e_flit, "R8", {15'd0, out_vld, out_flit},
        {15'd0, e_vld, e_flit});
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule